// File: doc/BRIEF.md
# Power Mode and Core Clock Slowdown Sequencer

This block decides which clock domains of a small microcontroller may run. Software asks for a power-down state by writing request bits into the status word. The block answers with enables for the CPU core, for timer 0, for the other timers and for the oscillator domain.

Two power-down states exist:
- **Deep stop (HALT):** gates every enable off. It is left only by an interrupt that cannot be masked, or by reset. When the interrupt wakes it, the core is held off until the oscillator reports that it is stable, or until a fixed wait of 256 input clocks runs out.
- **Light stop (IDLE):** keeps the oscillator domain and timer 0 alive. It returns to full running at once on a timer-0 overflow or on the non-maskable interrupt, with no stabilization wait.

A write-once enable register decides whether deep-stop requests are honoured. A slowdown bit in the feature register stretches the core machine cycle from 2 to 8 input clocks. While that bit is set, both power-down requests are refused. When the block leaves the running state, it pulses a reset to the serial peripherals. When it comes back through an interrupt or a timer overflow, it pulses a wake indication.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset the block is running: core_en, timer0_en, timers_en and osc_en are 1, periph_rst and wake_pulse are 0, core_tick has period 2, and deep-stop requests are not honoured.
- R2: A status-word write (sw_wr=1) with sw_halt_req=1, while running, with the halt enable at 1 and the slowdown bit at 0, enters HALT on the next clock edge: all four enables go to 0. This holds whatever sw_idle_req is.
- R3: A status-word write with sw_idle_req=1, while running, with the slowdown bit at 0 and HALT not taken, enters IDLE: only osc_en and timer0_en stay 1.
- R4: HALT ignores t0_ovf. A pulse on nmi moves it to a stabilization wait in which osc_en is 1 and the other enables are 0. The wait lasts until osc_stable=1 is seen, or for at most 256 cycles, and then the block runs.
- R5: In IDLE, nmi or t0_ovf returns the block to running on the next edge, with no stabilization wait.
- R6: Only the first write (hen_wr=1) to the halt enable after reset takes effect, with hen_val as its value. Later writes are ignored.
- R7: periph_rst is a single-cycle pulse in the first cycle after the block leaves the running state.
- R8: wake_pulse is a single-cycle pulse in the first cycle after an nmi or t0_ovf wake.
- R9: core_tick fires every 2 clocks when the slowdown bit is 0, and every 8 clocks when it is 1. A write with fx_wr=1 loads the bit from fx_slow. core_tick is 0 while the core is stopped.
- R10: While the slowdown bit is 1, HALT and IDLE requests are ignored.
- R11: Status-word writes made during a power-down state are ignored.
- R12: Asserting rst_n=0 in any state returns the block at once to the running state, and clears both the halt enable and its lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_wr | input | 1 | Status-word write strobe |
| sw_halt_req | input | 1 | Deep-stop request bit of the status word |
| sw_idle_req | input | 1 | Light-stop request bit of the status word |
| fx_wr | input | 1 | Feature-register write strobe |
| fx_slow | input | 1 | Slowdown bit value written |
| hen_wr | input | 1 | Halt-enable write strobe |
| hen_val | input | 1 | Halt-enable value written |
| nmi | input | 1 | Non-maskable interrupt, one-cycle pulse |
| t0_ovf | input | 1 | Timer-0 overflow, one-cycle pulse |
| osc_stable | input | 1 | Oscillator stabilization done |
| core_en | output | 1 | CPU core clock enable |
| timer0_en | output | 1 | Timer-0 clock enable |
| timers_en | output | 1 | Enable for the other timers |
| osc_en | output | 1 | Oscillator domain enable |
| core_tick | output | 1 | Divided core machine-cycle enable |
| periph_rst | output | 1 | Serial peripheral reset pulse |
| wake_pulse | output | 1 | Wake indication pulse |

## Verification
The assertions assume that nmi and t0_ovf arrive as pulses synchronous to clk. They also assume that register writes come only while the core runs, and that osc_stable matters only during the stabilization wait. The stimulus respects these assumptions:
- Every input is changed on the falling edge and held for exactly one cycle.
- Software writes are issued only in the running state, except for the deliberate writes during IDLE and HALT that test R11.
- osc_stable is raised only after an nmi wake from HALT.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_HALT = 2'd1,
    PM_IDLE = 2'd2,
    PM_STAB = 2'd3
  } pm_state_e;

  typedef struct packed {
    logic core;
    logic tmr0;
    logic tmrs;
    logic osc;
  } pm_en_t;

  // Which clock domains each state lets run.
  function automatic pm_en_t en_for(pm_state_e s);
    pm_en_t e;
    case (s)
      PM_RUN:  e = '{core: 1'b1, tmr0: 1'b1, tmrs: 1'b1, osc: 1'b1};
      PM_IDLE: e = '{core: 1'b0, tmr0: 1'b1, tmrs: 1'b0, osc: 1'b1};
      PM_STAB: e = '{core: 1'b0, tmr0: 1'b0, tmrs: 1'b0, osc: 1'b1};
      default: e = '{core: 1'b0, tmr0: 1'b0, tmrs: 1'b0, osc: 1'b0};
    endcase
    return e;
  endfunction

  // Last count value of a core machine cycle.
  function automatic int unsigned tick_last(logic slow, int unsigned fast_div,
                                            int unsigned slow_div);
    return slow ? slow_div - 1 : fast_div - 1;
  endfunction
endpackage

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ok,
  input  logic hen_wr,
  input  logic hen_val,
  input  logic fx_wr,
  input  logic fx_slow,
  output logic halt_en,
  output logic slow
);
  logic hen_locked;
  logic hen_take;

  assign hen_take = wr_ok && hen_wr && !hen_locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_en    <= 1'b0;
      hen_locked <= 1'b0;
      slow       <= 1'b0;
    end else begin
      if (hen_take) begin
        halt_en    <= hen_val;
        hen_locked <= 1'b1;
      end
      if (wr_ok && fx_wr) slow <= fx_slow;
    end
  end

  AST_HEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    hen_locked |=> $stable(halt_en)); // R6
endmodule

// File: rtl/pm_clk_div.sv
module pm_clk_div import pwr_seq_pkg::*; #(
  parameter int unsigned FAST_DIV = 2,
  parameter int unsigned SLOW_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(SLOW_DIV);

  logic [CW-1:0] cnt;
  logic [CW:0]   last_m;
  logic          wrap;

  assign last_m = (CW+1)'(tick_last(slow, FAST_DIV, SLOW_DIV));
  assign wrap   = ({1'b0, cnt} >= last_m);
  assign tick   = run && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (wrap) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R9
endmodule

// File: rtl/pm_fsm.sv
module pm_fsm import pwr_seq_pkg::*; #(
  parameter int unsigned STAB_CYC = 256
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sw_wr,
  input  logic      halt_req,
  input  logic      idle_req,
  input  logic      halt_en,
  input  logic      slow,
  input  logic      nmi,
  input  logic      t0_ovf,
  input  logic      osc_stable,
  output pm_state_e state,
  output logic      periph_rst,
  output logic      wake_pulse
);
  localparam int SW = (STAB_CYC > 1) ? $clog2(STAB_CYC) : 1;

  logic [SW-1:0] stab_cnt;
  logic go_halt, go_idle, wake_idle, wake_halt, stab_done;

  assign go_halt   = (state == PM_RUN) && sw_wr && halt_req && halt_en && !slow;
  assign go_idle   = (state == PM_RUN) && sw_wr && idle_req && !slow && !go_halt;
  assign wake_idle = (state == PM_IDLE) && (nmi || t0_ovf);
  assign wake_halt = (state == PM_HALT) && nmi;
  assign stab_done = osc_stable || (stab_cnt == SW'(STAB_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= PM_RUN;
      periph_rst <= 1'b0;
      wake_pulse <= 1'b0;
      stab_cnt   <= '0;
    end else begin
      periph_rst <= go_halt || go_idle;
      wake_pulse <= wake_idle || wake_halt;
      case (state)
        PM_RUN: begin
          if (go_halt) state <= PM_HALT;
          else if (go_idle) state <= PM_IDLE;
        end
        PM_HALT: begin
          if (wake_halt) begin
            state    <= PM_STAB;
            stab_cnt <= '0;
          end
        end
        PM_IDLE: if (wake_idle) state <= PM_RUN;
        default: begin
          if (stab_done) state <= PM_RUN;
          else stab_cnt <= stab_cnt + 1'b1;
        end
      endcase
    end
  end

  AST_PRST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst |=> !periph_rst); // R7
  AST_PRST_LEFT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst |-> (state == PM_HALT || state == PM_IDLE)); // R7
  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse); // R8
  AST_SLOW_HOLDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_RUN && slow) |=> state == PM_RUN); // R10
  AST_HALT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_RUN && !halt_en) |=> state != PM_HALT); // R2
  AST_IDLE_WAKE_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_IDLE && (nmi || t0_ovf)) |=> (state == PM_RUN && wake_pulse)); // R5
  AST_HALT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_HALT && !nmi) |=> state == PM_HALT); // R4
  AST_HALT_TO_STAB: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_HALT && nmi) |=> state == PM_STAB); // R4
  AST_IDLE_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_IDLE && !nmi && !t0_ovf) |=> state == PM_IDLE); // R11
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl import pwr_seq_pkg::*; #(
  parameter int unsigned FAST_DIV = 2,
  parameter int unsigned SLOW_DIV = 8,
  parameter int unsigned STAB_CYC = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_wr,
  input  logic sw_halt_req,
  input  logic sw_idle_req,
  input  logic fx_wr,
  input  logic fx_slow,
  input  logic hen_wr,
  input  logic hen_val,
  input  logic nmi,
  input  logic t0_ovf,
  input  logic osc_stable,
  output logic core_en,
  output logic timer0_en,
  output logic timers_en,
  output logic osc_en,
  output logic core_tick,
  output logic periph_rst,
  output logic wake_pulse
);
  pm_state_e state;
  pm_en_t    en;
  logic      halt_en, slow, in_run;

  assign in_run = (state == PM_RUN);
  assign en     = en_for(state);

  assign core_en   = en.core;
  assign timer0_en = en.tmr0;
  assign timers_en = en.tmrs;
  assign osc_en    = en.osc;

  pm_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_ok(in_run),
    .hen_wr(hen_wr), .hen_val(hen_val),
    .fx_wr(fx_wr), .fx_slow(fx_slow),
    .halt_en(halt_en), .slow(slow)
  );

  pm_clk_div #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .slow(slow), .run(en.core), .tick(core_tick)
  );

  pm_fsm #(.STAB_CYC(STAB_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr),
    .halt_req(sw_halt_req), .idle_req(sw_idle_req),
    .halt_en(halt_en), .slow(slow), .nmi(nmi), .t0_ovf(t0_ovf),
    .osc_stable(osc_stable), .state(state),
    .periph_rst(periph_rst), .wake_pulse(wake_pulse)
  );

  AST_HALT_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en) |-> (!core_en && !timer0_en && !timers_en && !core_tick)); // R2
  AST_TICK_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    core_tick |-> core_en); // R9
endmodule

// File: tb/pwr_seq_ctrl_bench.sv
module pwr_seq_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_wr = 0, sw_halt_req = 0, sw_idle_req = 0, fx_wr = 0, fx_slow = 0;
  logic hen_wr = 0, hen_val = 0, nmi = 0, t0_ovf = 0, osc_stable = 0;
  logic core_en, timer0_en, timers_en, osc_en, core_tick, periph_rst, wake_pulse;

  localparam int unsigned STAB = 256;

  // input vector: sw_wr halt idle fx_wr fx_slow hen_wr hen_val nmi t0 stab
  localparam logic [9:0] I_NONE = 10'h000, I_HALT = 10'h300, I_IDLE = 10'h280,
                         I_BOTH = 10'h380, I_SLOW1 = 10'h060, I_SLOW0 = 10'h040,
                         I_HEN1 = 10'h018, I_HEN0 = 10'h010, I_NMI = 10'h004,
                         I_T0 = 10'h002, I_STB = 10'h001;
  // outputs: core tmr0 tmrs osc prst wake
  localparam logic [5:0] O_RUN = 6'b111100, O_HALT = 6'b000000, O_HALT0 = 6'b000010,
                         O_IDLE = 6'b010100, O_IDLE0 = 6'b010110,
                         O_STAB0 = 6'b000101, O_STAB = 6'b000100, O_WOKE = 6'b111101;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [5:0] q_exp[$];
  string      q_tag[$];

  always #2 clk = ~clk;

  pwr_seq_ctrl u_pwr_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_halt_req(sw_halt_req),
    .sw_idle_req(sw_idle_req), .fx_wr(fx_wr), .fx_slow(fx_slow),
    .hen_wr(hen_wr), .hen_val(hen_val), .nmi(nmi), .t0_ovf(t0_ovf),
    .osc_stable(osc_stable), .core_en(core_en), .timer0_en(timer0_en),
    .timers_en(timers_en), .osc_en(osc_en), .core_tick(core_tick),
    .periph_rst(periph_rst), .wake_pulse(wake_pulse)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // driver: apply one cycle of input and queue the outputs expected after the edge
  task automatic step(logic [9:0] iv, logic [5:0] exp, string tag);
    @(negedge clk);
    {sw_wr, sw_halt_req, sw_idle_req, fx_wr, fx_slow,
     hen_wr, hen_val, nmi, t0_ovf, osc_stable} = iv;
    q_exp.push_back(exp);
    q_tag.push_back(tag);
  endtask

  // monitor: compare right after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_exp.size() > 0) begin
        logic [5:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        chk(t, {core_en, timer0_en, timers_en, osc_en, periph_rst, wake_pulse}, e);
      end
    end
  end

  task automatic count_ticks(int cycles, int exp, string tag);
    int n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk);
      #1;
      if (core_tick) n++;
    end
    chk(tag, n, exp);
  endtask

  task automatic wait_run(int exp, string tag);
    int n = 0;
    @(negedge clk);
    {sw_wr, sw_halt_req, sw_idle_req, fx_wr, fx_slow,
     hen_wr, hen_val, nmi, t0_ovf, osc_stable} = I_NONE;
    for (int i = 0; i < 1000; i++) begin
      @(posedge clk);
      #1;
      if (core_en) break;
      n++;
    end
    chk(tag, n, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(I_NONE, O_RUN, "R1 reset state");
    count_ticks(16, 8, "R1 R9 normal tick period");

    // HALT refused until enabled
    step(I_HALT, O_RUN, "R6 R1 halt not enabled after reset");
    step(I_NONE, O_RUN, "R6 still running");
    step(I_HEN1, O_RUN, "R6 first enable write");
    step(I_HALT, O_HALT0, "R2 R7 halt entry with peripheral reset");
    step(I_NONE, O_HALT, "R7 reset pulse single");
    step(I_T0, O_HALT, "R4 timer overflow ignored in halt");
    step(I_IDLE, O_HALT, "R11 request ignored in halt");
    step(I_NONE, O_HALT, "R4 halt held");
    count_ticks(8, 0, "R9 no tick in halt");
    step(I_NMI, O_STAB0, "R4 R8 nmi wake to stabilization");
    wait_run(STAB - 1, "R4 full stabilization wait");
    step(I_NONE, O_RUN, "R4 running after wait");

    // write-once lock
    step(I_HEN0, O_RUN, "R6 second write");
    step(I_HALT, O_HALT0, "R6 enable kept after ignored write");
    step(I_NONE, O_HALT, "R2 halt");
    step(I_NMI, O_STAB0, "R4 nmi wake");
    step(I_STB, O_RUN, "R4 stable ends wait early");
    step(I_NONE, O_RUN, "R8 wake single");

    // IDLE and its wakes
    step(I_IDLE, O_IDLE0, "R3 R7 idle entry");
    step(I_NONE, O_IDLE, "R3 idle held");
    step(I_HALT, O_IDLE, "R11 request ignored in idle");
    step(I_NONE, O_IDLE, "R11 idle held");
    step(I_T0, O_WOKE, "R5 R8 timer wake");
    step(I_NONE, O_RUN, "R8 wake single");
    step(I_IDLE, O_IDLE0, "R3 idle entry again");
    step(I_NONE, O_IDLE, "R3 idle");
    step(I_NMI, O_WOKE, "R5 nmi wake without wait");
    step(I_NONE, O_RUN, "R5 running");

    // both request bits: HALT wins
    step(I_BOTH, O_HALT0, "R2 halt priority over idle");
    step(I_NONE, O_HALT, "R2 halt");
    step(I_NMI, O_STAB0, "R4 wake");
    step(I_STB, O_RUN, "R4 stable");
    step(I_NONE, O_RUN, "R4 run");

    // SLOW
    step(I_SLOW1, O_RUN, "R9 slow set");
    for (int i = 0; i < 10; i++) step(I_NONE, O_RUN, "R9 slow run");
    count_ticks(16, 2, "R9 slow tick period");
    step(I_HALT, O_RUN, "R10 halt blocked by slow");
    step(I_NONE, O_RUN, "R10 run");
    step(I_IDLE, O_RUN, "R10 idle blocked by slow");
    step(I_NONE, O_RUN, "R10 run");
    step(I_SLOW0, O_RUN, "R9 slow cleared");
    for (int i = 0; i < 4; i++) step(I_NONE, O_RUN, "R9 normal run");
    count_ticks(16, 8, "R9 normal tick after slow");
    step(I_IDLE, O_IDLE0, "R10 idle allowed after clear");
    step(I_NONE, O_IDLE, "R3 idle");

    // reset from IDLE
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R12 reset from idle", {core_en, timer0_en, timers_en, osc_en, periph_rst, wake_pulse}, O_RUN);
    rst_n = 1'b1;
    step(I_HALT, O_RUN, "R12 R6 reset clears enable");
    step(I_HEN1, O_RUN, "R12 R6 lock cleared");
    step(I_HALT, O_HALT0, "R12 halt after re-enable");
    step(I_NONE, O_HALT, "R12 halt");
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R12 reset from halt", {core_en, timer0_en, timers_en, osc_en, periph_rst, wake_pulse}, O_RUN);
    rst_n = 1'b1;
    step(I_NONE, O_RUN, "R12 run after reset");
    step(I_NONE, O_RUN, "R12 run");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule